// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits in front of a parallel NOR flash array and interprets the bus write cycles aimed at it. It follows the multi-write command protocol. A command is opened by two address-qualified unlock writes and then named by a command byte. From that it decides which view the read path should present: array data, device identification (autoselect), the CFI query table, or erase status. It also issues the program and erase requests that the storage array carries out.

A program request carries the full byte address and the data byte. The array is expected to AND the byte into the old contents, so programming can only clear bits. An erase request carries a chip/sector selector and the sector base address. An unlock-bypass mode lets software skip the two unlock writes for each command until bypass is left. A chip or sector erase holds the sequencer busy for a fixed number of cycles, and it ignores writes during that time. The device width of 1, 2 or 4 bytes is a parameter. It sets how far the byte address is shifted before the unlock comparison.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, mode_o is 0 (array read), busy_o, prog_req_o and erase_req_o are 0.
- R2: A command is accepted only after data 0xAA at unlock address 0 and then data 0x55 at unlock address 1, with the command byte written at unlock address 0. Any write whose data or address does not match the expected step returns to array read, so a later command byte has no effect.
- R3: The compared address is the byte address shifted right by 0, 1 or 2 for widths of 1, 2 or 4 bytes. Only its low 11 bits are compared: byte-offset bits below the shift and bits above them do not affect matching.
- R4: Command 0x90 enters autoselect mode (mode_o = 1). Every other unlocked command byte apart from 0xA0, 0x80 and 0x20 leaves mode_o at 0.
- R5: Data 0x98 at compared address 0x55 enters CFI mode (mode_o = 2) from array read or from autoselect. Any write in CFI mode returns to array read.
- R6: Data 0xF0 returns to array read from any unlock step, erase prefix step or autoselect.
- R7: After command 0xA0, the next write raises prog_req_o for exactly one cycle, with prog_addr_o and prog_data_o equal to that write's byte address and data. This holds even for data 0xF0, and the sequencer then returns to array read.
- R8: Command 0x20 enters unlock-bypass. In bypass, command bytes are taken at any address without unlock writes, 0xF0 keeps bypass, and 0x90 followed by 0x00 leaves bypass.
- R9: Command 0x80, then a second unlock pair, then 0x10 at unlock address 0 raises erase_req_o for one cycle with erase_chip_o = 1 and erase_addr_o = 0. 0x10 at any other address starts nothing.
- R10: Command 0x80, a second unlock pair, then 0x30 at any address raises erase_req_o with erase_chip_o = 0 and erase_addr_o equal to that address with its low SECT_LOG2 bits cleared.
- R11: From the cycle erase_req_o is raised, busy_o = 1 and mode_o = 3 for exactly ERASE_CYCLES cycles, all writes including 0xF0 and unlock sequences are ignored, and the sequencer then returns to array read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write cycle strobe, one write per cycle it is high |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 8 | Data byte of the write |
| mode_o | output | 2 | Read view: 0 array, 1 autoselect, 2 CFI, 3 status |
| busy_o | output | 1 | Erase in progress |
| prog_req_o | output | 1 | One-cycle program request |
| prog_addr_o | output | ADDR_W | Byte address to program |
| prog_data_o | output | 8 | Data to AND into the array |
| erase_req_o | output | 1 | One-cycle erase request |
| erase_chip_o | output | 1 | 1 for chip erase, 0 for sector erase |
| erase_addr_o | output | ADDR_W | Sector base byte address (0 for chip erase) |

## Verification
The unlock progress and the bypass flag have no output of their own, so each partial sequence is made visible by finishing it with an autoselect command or a program cycle and reading mode_o or prog_req_o. The ignored-write window of an erase is the hardest case to reach. The bench starts an erase and then, while the busy count runs, issues a reset and a complete unlock-plus-autoselect sequence. It then checks that the busy edge falls on the expected cycle and that autoselect was never entered. Unlock data bytes, command bytes and single-bit address flips are swept across their whole range.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int CMP_W = 11;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_CMD,
        ST_PROG,
        ST_EUNL0,
        ST_EUNL1,
        ST_ECMD,
        ST_ERASE,
        ST_AUTO,
        ST_CFI
    } seq_state_e;

    typedef enum logic [1:0] {
        VIEW_ARRAY   = 2'd0,
        VIEW_AUTOSEL = 2'd1,
        VIEW_CFI     = 2'd2,
        VIEW_STATUS  = 2'd3
    } seq_view_e;

    localparam logic [7:0] D_UNLOCK_A  = 8'hAA;
    localparam logic [7:0] D_UNLOCK_B  = 8'h55;
    localparam logic [7:0] D_RESET     = 8'hF0;
    localparam logic [7:0] D_QUERY     = 8'h98;
    localparam logic [7:0] D_ERASE_PRE = 8'h80;
    localparam logic [7:0] D_AUTOSEL   = 8'h90;
    localparam logic [7:0] D_PROGRAM   = 8'hA0;
    localparam logic [7:0] D_BYPASS    = 8'h20;
    localparam logic [7:0] D_CHIP      = 8'h10;
    localparam logic [7:0] D_SECTOR    = 8'h30;
    localparam logic [7:0] D_BYP_EXIT  = 8'h00;

    localparam logic [CMP_W-1:0] QUERY_ADDR = 11'h055;

endpackage

// File: rtl/nor_unlock_match.sv
module nor_unlock_match
    import nor_seq_pkg::*;
#(
    parameter logic [CMP_W-1:0] UNLOCK_ADDR0 = 11'h555,
    parameter logic [CMP_W-1:0] UNLOCK_ADDR1 = 11'h2AA
) (
    input  logic [CMP_W-1:0] cmp_addr_i,
    output logic             hit0_o,
    output logic             hit1_o,
    output logic             hit_query_o
);

    always_comb begin
        hit0_o      = (cmp_addr_i == UNLOCK_ADDR0);
        hit1_o      = (cmp_addr_i == UNLOCK_ADDR1);
        hit_query_o = (cmp_addr_i == QUERY_ADDR);
    end

endmodule

// File: rtl/nor_sector_align.sv
module nor_sector_align #(
    parameter int ADDR_W    = 20,
    parameter int SECT_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] base_o
);

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        if (i < SECT_LOG2) begin : g_clear
            assign base_o[i] = 1'b0 & addr_i[i];
        end else begin : g_keep
            assign base_o[i] = addr_i[i];
        end
    end

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic last_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);
    assign last_o = (cnt_q == CW'(1));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int               ADDR_W       = 20,
    parameter int               WIDTH_BYTES  = 1,
    parameter logic [CMP_W-1:0] UNLOCK_ADDR0 = 11'h555,
    parameter logic [CMP_W-1:0] UNLOCK_ADDR1 = 11'h2AA,
    parameter int               SECT_LOG2    = 12,
    parameter int               ERASE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [1:0]        mode_o,
    output logic              busy_o,
    output logic              prog_req_o,
    output logic [ADDR_W-1:0] prog_addr_o,
    output logic [7:0]        prog_data_o,
    output logic              erase_req_o,
    output logic              erase_chip_o,
    output logic [ADDR_W-1:0] erase_addr_o
);

    localparam int ADDR_SHIFT = (WIDTH_BYTES == 4) ? 2 : ((WIDTH_BYTES == 2) ? 1 : 0);

    typedef struct packed {
        seq_state_e        st;
        logic              bypass;
        logic              prog_req;
        logic              erase_req;
        logic              erase_chip;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [CMP_W-1:0]  cmp_addr;
    logic              hit0, hit1, hit_query;
    logic [ADDR_W-1:0] sect_base;
    logic              tmr_busy, tmr_last;
    seq_state_e        home;

    assign cmp_addr = wr_addr_i[ADDR_SHIFT +: CMP_W];

    nor_unlock_match #(
        .UNLOCK_ADDR0 (UNLOCK_ADDR0),
        .UNLOCK_ADDR1 (UNLOCK_ADDR1)
    ) u_match (
        .cmp_addr_i  (cmp_addr),
        .hit0_o      (hit0),
        .hit1_o      (hit1),
        .hit_query_o (hit_query)
    );

    nor_sector_align #(
        .ADDR_W    (ADDR_W),
        .SECT_LOG2 (SECT_LOG2)
    ) u_align (
        .addr_i (wr_addr_i),
        .base_o (sect_base)
    );

    nor_busy_timer #(
        .CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (seq_d.erase_req),
        .busy_o  (tmr_busy),
        .last_o  (tmr_last)
    );

    always_comb begin
        seq_d           = seq_q;
        seq_d.prog_req  = 1'b0;
        seq_d.erase_req = 1'b0;
        home            = seq_q.bypass ? ST_CMD : ST_IDLE;

        if (seq_q.st == ST_ERASE) begin
            if (tmr_last) begin
                seq_d.st = home;
            end
        end else if (wr_en_i) begin
            if (wr_data_i == D_RESET && seq_q.st != ST_PROG) begin
                seq_d.st = home;
            end else begin
                unique case (seq_q.st)
                    ST_IDLE: begin
                        if (hit_query && wr_data_i == D_QUERY) begin
                            seq_d.st = ST_CFI;
                        end else if (hit0 && wr_data_i == D_UNLOCK_A) begin
                            seq_d.st = ST_UNL1;
                        end else begin
                            seq_d.st = ST_IDLE;
                        end
                    end
                    ST_UNL1: begin
                        seq_d.st = (hit1 && wr_data_i == D_UNLOCK_B) ? ST_CMD : home;
                    end
                    ST_CMD: begin
                        if (seq_q.bypass && hit_query && wr_data_i == D_QUERY) begin
                            seq_d.st = ST_CFI;
                        end else if (seq_q.bypass || hit0) begin
                            unique case (wr_data_i)
                                D_PROGRAM:   seq_d.st = ST_PROG;
                                D_ERASE_PRE: seq_d.st = ST_EUNL0;
                                D_AUTOSEL:   seq_d.st = ST_AUTO;
                                D_BYPASS: begin
                                    seq_d.bypass = 1'b1;
                                    seq_d.st     = ST_CMD;
                                end
                                default:     seq_d.st = home;
                            endcase
                        end else begin
                            seq_d.st = home;
                        end
                    end
                    ST_PROG: begin
                        seq_d.prog_req = 1'b1;
                        seq_d.addr     = wr_addr_i;
                        seq_d.data     = wr_data_i;
                        seq_d.st       = home;
                    end
                    ST_EUNL0: begin
                        seq_d.st = (hit0 && wr_data_i == D_UNLOCK_A) ? ST_EUNL1 : home;
                    end
                    ST_EUNL1: begin
                        seq_d.st = (hit1 && wr_data_i == D_UNLOCK_B) ? ST_ECMD : home;
                    end
                    ST_ECMD: begin
                        if (hit0 && wr_data_i == D_CHIP) begin
                            seq_d.st         = ST_ERASE;
                            seq_d.erase_req  = 1'b1;
                            seq_d.erase_chip = 1'b1;
                            seq_d.addr       = '0;
                        end else if (wr_data_i == D_SECTOR) begin
                            seq_d.st         = ST_ERASE;
                            seq_d.erase_req  = 1'b1;
                            seq_d.erase_chip = 1'b0;
                            seq_d.addr       = sect_base;
                        end else begin
                            seq_d.st = home;
                        end
                    end
                    ST_AUTO: begin
                        if (hit_query && wr_data_i == D_QUERY) begin
                            seq_d.st = ST_CFI;
                        end else if (seq_q.bypass && wr_data_i == D_BYP_EXIT) begin
                            seq_d.bypass = 1'b0;
                            seq_d.st     = ST_IDLE;
                        end else begin
                            seq_d.st = home;
                        end
                    end
                    default: begin
                        seq_d.st = home;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, bypass: 1'b0, prog_req: 1'b0, erase_req: 1'b0,
                       erase_chip: 1'b0, addr: '0, data: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        unique case (seq_q.st)
            ST_ERASE: mode_o = VIEW_STATUS;
            ST_AUTO:  mode_o = VIEW_AUTOSEL;
            ST_CFI:   mode_o = VIEW_CFI;
            default:  mode_o = VIEW_ARRAY;
        endcase
    end

    assign busy_o       = tmr_busy;
    assign prog_req_o   = seq_q.prog_req;
    assign prog_addr_o  = seq_q.addr;
    assign prog_data_o  = seq_q.data;
    assign erase_req_o  = seq_q.erase_req;
    assign erase_chip_o = seq_q.erase_chip;
    assign erase_addr_o = seq_q.addr;

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
    parameter int ADDR_W    = 20,
    parameter int SECT_LOG2 = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_o,
    input logic              busy_o,
    input logic              prog_req_o,
    input logic              erase_req_o,
    input logic              erase_chip_o,
    input logic [ADDR_W-1:0] erase_addr_o
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << SECT_LOG2) - 64'd1);

    a_r1_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req_o && erase_req_o));

    a_r7_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |=> !prog_req_o);

    a_r9_chip_base_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_o && erase_chip_o) |-> (erase_addr_o == '0));

    a_r10_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_o && !erase_chip_o) |-> ((erase_addr_o & LOW_MASK) == '0));

    a_r11_req_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o |-> busy_o);

    a_r11_busy_status_view: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (mode_o == 2'd3));

    a_r11_no_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (!erase_req_o && !prog_req_o));

    a_r11_busy_exit_array: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (mode_o == 2'd0));

endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
    .ADDR_W    (ADDR_W),
    .SECT_LOG2 (SECT_LOG2)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_o       (mode_o),
    .busy_o       (busy_o),
    .prog_req_o   (prog_req_o),
    .erase_req_o  (erase_req_o),
    .erase_chip_o (erase_chip_o),
    .erase_addr_o (erase_addr_o)
);

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module nor_cmd_seq_bench;

    localparam int          AW    = 20;
    localparam int          WB    = 2;
    localparam int          SL2   = 12;
    localparam int          ECYC  = 16;
    localparam logic [10:0] UA0   = 11'h555;
    localparam logic [10:0] UA1   = 11'h2AA;
    localparam logic [AW-1:0] A0B = AW'(UA0) << 1;
    localparam logic [AW-1:0] A1B = AW'(UA1) << 1;
    localparam logic [AW-1:0] QB  = AW'(11'h055) << 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [1:0]    mode;
    logic          busy, prog_req, erase_req, erase_chip;
    logic [AW-1:0] prog_addr, erase_addr;
    logic [7:0]    prog_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nor_cmd_seq #(
        .ADDR_W (AW), .WIDTH_BYTES (WB), .UNLOCK_ADDR0 (UA0), .UNLOCK_ADDR1 (UA1),
        .SECT_LOG2 (SL2), .ERASE_CYCLES (ECYC)
    ) u_nor_cmd_seq (
        .clk (clk), .rst_n (rst_n), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
        .wr_data_i (wr_data), .mode_o (mode), .busy_o (busy), .prog_req_o (prog_req),
        .prog_addr_o (prog_addr), .prog_data_o (prog_data), .erase_req_o (erase_req),
        .erase_chip_o (erase_chip), .erase_addr_o (erase_addr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(A0B, 8'hAA);
        wr(A1B, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(A0B, 8'h80);
        unlock();
    endtask

    task automatic wait_erase(input string req);
        for (int i = 1; i < ECYC; i++) @(negedge clk);
        chk(req, "busy on last cycle", busy, 1);
        @(negedge clk);
        chk(req, "busy after window", busy, 0);
        chk(req, "view after window", mode, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "view", mode, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "prog_req", prog_req, 0);
        chk("R1", "erase_req", erase_req, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: first unlock data sweep
        for (int d = 0; d < 256; d++) begin
            wr(A0B, 8'(d)); wr(A1B, 8'h55); wr(A0B, 8'h90);
            chk("R2", "first unlock byte sweep", mode, (d == 8'hAA) ? 1 : 0);
            wr(A0B, 8'hF0);
        end
        // R2: second unlock data sweep
        for (int d = 0; d < 256; d++) begin
            wr(A0B, 8'hAA); wr(A1B, 8'(d)); wr(A0B, 8'h90);
            chk("R2", "second unlock byte sweep", mode, (d == 8'h55) ? 1 : 0);
            wr(A0B, 8'hF0);
        end
        // R2: command byte at wrong address
        unlock(); wr(A1B, 8'h90);
        chk("R2", "command off unlock address", mode, 0);

        // R3: single-bit flips of the compared address fail
        for (int b = 0; b < 11; b++) begin
            wr(AW'(UA0 ^ 11'(1 << b)) << 1, 8'hAA); wr(A1B, 8'h55); wr(A0B, 8'h90);
            chk("R3", "flipped compared bit", mode, 0);
            wr(A0B, 8'hF0);
        end
        wr(A0B | AW'(1), 8'hAA); wr(A1B | AW'(1), 8'h55); wr(A0B, 8'h90);
        chk("R3", "byte-lane bit ignored", mode, 1);
        wr(A0B, 8'hF0);
        wr(A0B | AW'(20'h80000), 8'hAA); wr(A1B | AW'(20'h41000), 8'h55); wr(A0B, 8'h90);
        chk("R3", "upper bits ignored", mode, 1);
        wr(A0B, 8'hF0);
        wr(AW'(UA0), 8'hAA); wr(A1B, 8'h55); wr(A0B, 8'h90);
        chk("R3", "unscaled address rejected", mode, 0);

        // R4: command byte sweep
        for (int c = 0; c < 256; c++) begin
            if (c == 8'h20 || c == 8'hA0) continue;
            unlock(); wr(A0B, 8'(c));
            chk("R4", "command sweep view", mode, (c == 8'h90) ? 1 : 0);
            chk("R4", "command sweep no request", {prog_req, erase_req}, 0);
            wr(A0B, 8'hF0);
        end

        // R5: CFI entry and exit
        wr(QB, 8'h98);
        chk("R5", "query from array", mode, 2);
        wr(A0B, 8'h00);
        chk("R5", "any write leaves query", mode, 0);
        unlock(); wr(A0B, 8'h90); wr(QB, 8'h98);
        chk("R5", "query from autoselect", mode, 2);
        wr(QB, 8'hF0);
        chk("R5", "reset leaves query", mode, 0);
        wr(AW'(11'h055), 8'h98);
        chk("R5", "unscaled query address", mode, 0);

        // R6: reset mid-sequence
        wr(A0B, 8'hAA); wr(A0B, 8'hF0); wr(A1B, 8'h55); wr(A0B, 8'h90);
        chk("R6", "reset after first unlock", mode, 0);
        unlock(); wr(A0B, 8'h80); wr(A0B, 8'hF0); unlock(); wr(A0B, 8'h10);
        chk("R6", "reset after erase prefix", {busy, erase_req}, 0);
        wr(A0B, 8'hF0);
        unlock(); wr(A0B, 8'h90); wr(A1B, 8'hF0);
        chk("R6", "reset from autoselect", mode, 0);

        // R7: program requests
        for (int i = 0; i < 6; i++) begin
            logic [AW-1:0] pa;
            logic [7:0]    pd;
            pa = AW'(i * 32'h2D3B1 + 7);
            pd = (i == 3) ? 8'hF0 : 8'(i * 37 + 5);
            unlock(); wr(A0B, 8'hA0); wr(pa, pd);
            chk("R7", "prog_req", prog_req, 1);
            chk("R7", "prog_addr", prog_addr, pa);
            chk("R7", "prog_data", prog_data, pd);
            @(negedge clk);
            chk("R7", "prog_req one cycle", prog_req, 0);
            chk("R7", "view after program", mode, 0);
        end

        // R8: unlock bypass
        unlock(); wr(A0B, 8'h20);
        for (int i = 0; i < 3; i++) begin
            wr(AW'(32'h1234 + i), 8'hA0); wr(AW'(32'h3000 + i), 8'(8'h5A + i));
            chk("R8", "bypass program req", prog_req, 1);
            chk("R8", "bypass program addr", prog_addr, AW'(32'h3000 + i));
        end
        wr(A1B, 8'hF0); wr(AW'(32'h777), 8'hA0); wr(AW'(32'h10), 8'h01);
        chk("R8", "bypass kept after reset", prog_req, 1);
        wr(AW'(32'h99), 8'h90);
        chk("R8", "bypass autoselect", mode, 1);
        wr(AW'(32'h99), 8'h00);
        chk("R8", "bypass exit view", mode, 0);
        wr(AW'(32'h777), 8'hA0); wr(AW'(32'h10), 8'h01);
        chk("R8", "no program after exit", prog_req, 0);

        // R9 / R11: chip erase with ignored writes
        erase_prefix(); wr(A1B, 8'h10);
        chk("R9", "chip erase off address", {busy, erase_req}, 0);
        chk("R9", "chip erase off address view", mode, 0);
        erase_prefix(); wr(A0B, 8'h10);
        chk("R9", "erase_req", erase_req, 1);
        chk("R9", "erase_chip", erase_chip, 1);
        chk("R9", "erase_addr", erase_addr, 0);
        chk("R11", "view busy", mode, 3);
        wr(A0B, 8'hF0); unlock(); wr(A0B, 8'h90);
        chk("R11", "writes ignored while busy", mode, 3);
        chk("R11", "no request while busy", {prog_req, erase_req}, 0);
        for (int i = 9; i < ECYC; i++) @(negedge clk);
        chk("R11", "busy on last cycle", busy, 1);
        @(negedge clk);
        chk("R11", "busy ends", busy, 0);
        chk("R11", "autoselect never entered", mode, 0);

        // R10: sector erase sweep
        for (int i = 0; i < 12; i++) begin
            logic [AW-1:0] sa;
            sa = AW'(i * 32'h1F357 + 32'h0ABC);
            erase_prefix(); wr(sa, 8'h30);
            chk("R10", "sector erase_req", erase_req, 1);
            chk("R10", "sector erase_chip", erase_chip, 0);
            chk("R10", "sector base", erase_addr, (sa >> SL2) << SL2);
            wait_erase("R11");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule